// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

This block copies the contents of a 1K-bit serial EEPROM, organised as 64 words of 16 bits, into a bank of byte-wide configuration registers. A load runs on its own when reset ends. Software can start another load by writing the auto-load code into the two-bit mode field of the command register. Each word is fetched with its own read transaction on a three-wire-plus-data-out serial link. The block drives chip select, serial clock and data-in, and samples data-out. The serial clock runs at the system clock divided by a programmable even number.

The mode field selects one of four behaviours. Normal mode leaves the serial pins idle. Auto-load mode runs the sequencer. Programming mode hands the chip select, clock and data-in pins to software, which sets them through the command register. Config-write mode opens the loaded registers to host writes. In auto-load and programming modes the low four status bits show the live pin levels, so software can bit-bang the device and read back what it returns.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is held and in the first cycle after it ends, `busy` is 1 and the mode field (`cmd_rdata[7:6]`) reads 01 (auto-load). Mode codes: 00 normal, 01 auto-load, 10 programming, 11 config-write.
- R2: A load reads word addresses 0 to N_WORDS-1 in ascending order (25 words by default, which covers byte addresses 00h to 31h). Each word is fetched with the 9-bit command start 1, opcode 10, then the 6-bit word address, all MSB first on `ee_di`.
- R3: The 16 data bits are taken MSB first from `ee_do`, starting on the serial clock after the dummy 0 bit. Word w is stored little-endian: bits 7:0 go to byte 2w and bits 15:8 go to byte 2w+1.
- R4: When the last word has been stored, `busy` falls and the mode field goes back to 00 in the same cycle.
- R5: Between two words of a load, `ee_cs` stays low for at least one full serial clock period (2*`sk_half` system cycles).
- R6: `ee_sk` is high for `sk_half` system cycles and low for `sk_half` cycles. During a load it is high only while `ee_cs` is high.
- R7: A host write (`cfg_we`) changes a loaded register only when the mode is 11 and no load is running. In any other mode the write has no effect.
- R8: In programming mode, writing the command register with bits 3, 2 and 1 set drives `ee_cs`, `ee_sk` and `ee_di` to those values. In modes 01 and 10, `cmd_rdata[3:0]` shows {cs, sk, di, do} live.
- R9: In modes 00 and 11, `cmd_rdata[3:0]` reads 0 and `ee_cs`, `ee_sk` and `ee_di` are low.
- R10: Writing mode 01 while idle starts a new load. The new load overwrites every loaded byte, including bytes that the host wrote earlier.
- R11: Command register writes are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sk_half | input | DIV_W | Serial clock half period in system cycles (0 is treated as 1) |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | [7:6] mode, [3] cs, [2] sk, [1] di for programming mode |
| cmd_rdata | output | 8 | [7:6] mode, [5] busy, [4] 0, [3:0] {cs, sk, di, do} mirror |
| cfg_we | input | 1 | Host write strobe into the loaded registers |
| cfg_waddr | input | BA_W | Host write byte address |
| cfg_wdata | input | 8 | Host write data |
| cfg_raddr | input | BA_W | Read byte address |
| cfg_rdata | output | 8 | Read data; 0 beyond the loaded range |
| busy | output | 1 | A load is pending or in progress |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data towards the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The checks assume that `sk_half` does not change while a load is running. The bench changes it only while `busy` is low. They also assume that the EEPROM puts its dummy 0 and its data bits on `ee_do` at rising serial clock edges and holds each bit through the following high phase. The bench's behavioural EEPROM does exactly that, and it drives `ee_do` low whenever chip select is low. The protection property compares only the byte being read back, so the bench holds `cfg_raddr` steady around each write it uses to test protection.

// File: rtl/eel_pkg.sv
package eel_pkg;

  localparam int EE_ADDR_W  = 6;   // 1K bits / 16-bit words = 64 words
  localparam int CMD_BITS   = 9;   // start + opcode + address
  localparam int DATA_BITS  = 16;
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_AUTOLOAD = 2'b01,
    MODE_PROG     = 2'b10,
    MODE_CFGWR    = 2'b11
  } eel_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'b00,
    S_LO   = 2'b01,
    S_HI   = 2'b10,
    S_GAP  = 2'b11
  } eel_state_e;

  // Read command frame: start bit, opcode 10, word address
  function automatic logic [CMD_BITS-1:0] eel_read_frame(input logic [EE_ADDR_W-1:0] a);
    return {1'b1, 2'b10, a};
  endfunction

  // Bit sent at clock position idx (0 = first, MSB first)
  function automatic logic eel_cmd_bit(input logic [EE_ADDR_W-1:0] a, input int idx);
    logic [CMD_BITS-1:0] f;
    f = eel_read_frame(a);
    return f[CMD_BITS-1-idx];
  endfunction

  // Little-endian byte select within a loaded word
  function automatic logic [7:0] eel_word_byte(input logic [DATA_BITS-1:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

endpackage

// File: rtl/eel_tick.sv
module eel_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim  = (half == '0) ? DIV_W'(1) : half;
  assign tick = en && (cnt_q == lim - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!en || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/eel_seq.sv
module eel_seq
  import eel_pkg::*;
#(
  parameter int N_WORDS = 25,
  parameter int DIV_W   = 8,
  localparam int WORD_W = $clog2(N_WORDS),
  localparam int BIT_W  = $clog2(FRAME_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DIV_W-1:0]     sk_half,
  input  logic                 ee_do,
  output logic                 cs,
  output logic                 sk,
  output logic                 di,
  output logic                 active,
  output logic                 ld_we,
  output logic [WORD_W-1:0]    ld_word,
  output logic [DATA_BITS-1:0] ld_data,
  output logic                 done
);
  eel_state_e           state_q;
  logic [WORD_W-1:0]    word_q;
  logic [BIT_W-1:0]     bit_q;
  logic                 gap_q;
  logic [DATA_BITS-1:0] shreg_q;
  logic                 tick;
  logic                 capture, last_bit, last_word, word_done;

  eel_tick #(.DIV_W(DIV_W)) tick_i (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state_q != S_IDLE),
    .half (sk_half),
    .tick (tick)
  );

  assign capture   = bit_q >= BIT_W'(CMD_BITS);
  assign last_bit  = bit_q == BIT_W'(FRAME_BITS-1);
  assign last_word = word_q == WORD_W'(N_WORDS-1);
  assign word_done = (state_q == S_HI) && tick && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      word_q  <= '0;
      bit_q   <= '0;
      gap_q   <= 1'b0;
      shreg_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_LO;
          word_q  <= '0;
          bit_q   <= '0;
        end
        S_LO: if (tick) state_q <= S_HI;
        S_HI: if (tick) begin
          if (capture) shreg_q <= {shreg_q[DATA_BITS-2:0], ee_do};
          if (last_bit) begin
            if (last_word) state_q <= S_IDLE;
            else begin
              state_q <= S_GAP;
              gap_q   <= 1'b0;
            end
          end else begin
            bit_q   <= bit_q + BIT_W'(1);
            state_q <= S_LO;
          end
        end
        S_GAP: if (tick) begin
          if (gap_q) begin
            state_q <= S_LO;
            bit_q   <= '0;
            word_q  <= word_q + WORD_W'(1);
          end else begin
            gap_q <= 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cs      = (state_q == S_LO) || (state_q == S_HI);
  assign sk      = (state_q == S_HI);
  assign di      = cs && !capture && eel_cmd_bit(EE_ADDR_W'(word_q), int'(bit_q));
  assign active  = (state_q != S_IDLE);
  assign ld_we   = word_done;
  assign ld_word = word_q;
  assign ld_data = {shreg_q[DATA_BITS-2:0], ee_do};
  assign done    = word_done && last_word;
endmodule

// File: rtl/eel_cfg_bank.sv
module eel_cfg_bank
  import eel_pkg::*;
#(
  parameter int N_WORDS = 25,
  parameter int BA_W    = 6,
  localparam int WORD_W  = $clog2(N_WORDS),
  localparam int N_BYTES = 2 * N_WORDS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_we,
  input  logic [WORD_W-1:0]    ld_word,
  input  logic [DATA_BITS-1:0] ld_data,
  input  logic                 host_we,
  input  logic [BA_W-1:0]      host_addr,
  input  logic [7:0]           host_data,
  input  logic [BA_W-1:0]      raddr,
  output logic [7:0]           rdata
);
  logic [N_BYTES*8-1:0] flat;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(g / 2);
    localparam logic              MY_HI   = 1'(g % 2);
    logic [7:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byte_q <= 8'h00;
      else if (ld_we && ld_word == MY_WORD)
        byte_q <= eel_word_byte(ld_data, MY_HI);
      else if (host_we && host_addr == BA_W'(g))
        byte_q <= host_data;
    end

    assign flat[g*8 +: 8] = byte_q;
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < N_BYTES; i++)
      if (raddr == BA_W'(i)) rdata = flat[i*8 +: 8];
  end
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eel_pkg::*;
#(
  parameter int N_WORDS = 25,
  parameter int DIV_W   = 8,
  parameter int BA_W    = 6,
  localparam int WORD_W = $clog2(N_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] sk_half,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_wdata,
  output logic [7:0]       cmd_rdata,
  input  logic             cfg_we,
  input  logic [BA_W-1:0]  cfg_waddr,
  input  logic [7:0]       cfg_wdata,
  input  logic [BA_W-1:0]  cfg_raddr,
  output logic [7:0]       cfg_rdata,
  output logic             busy,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do
);
  eel_mode_e            mode_q;
  logic                 load_req_q;
  logic [2:0]           pin_sw_q;
  logic                 seq_start, seq_active, seq_done;
  logic                 seq_cs, seq_sk, seq_di;
  logic                 load_wr;
  logic [WORD_W-1:0]    load_word;
  logic [DATA_BITS-1:0] load_data;
  logic                 cmd_ok, host_wr_ok;
  logic [3:0]           mirror;

  assign seq_start  = load_req_q && !seq_active;
  assign busy       = load_req_q || seq_active;
  assign cmd_ok     = cmd_we && !busy;
  assign host_wr_ok = cfg_we && (mode_q == MODE_CFGWR) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_AUTOLOAD;
      load_req_q <= 1'b1;
      pin_sw_q   <= 3'b000;
    end else begin
      if (seq_start) load_req_q <= 1'b0;
      if (seq_done) begin
        mode_q <= MODE_NORMAL;
      end else if (cmd_ok) begin
        mode_q   <= eel_mode_e'(cmd_wdata[7:6]);
        pin_sw_q <= cmd_wdata[3:1];
        if (eel_mode_e'(cmd_wdata[7:6]) == MODE_AUTOLOAD) load_req_q <= 1'b1;
      end
    end
  end

  eel_seq #(.N_WORDS(N_WORDS), .DIV_W(DIV_W)) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (seq_start),
    .sk_half(sk_half),
    .ee_do  (ee_do),
    .cs     (seq_cs),
    .sk     (seq_sk),
    .di     (seq_di),
    .active (seq_active),
    .ld_we  (load_wr),
    .ld_word(load_word),
    .ld_data(load_data),
    .done   (seq_done)
  );

  eel_cfg_bank #(.N_WORDS(N_WORDS), .BA_W(BA_W)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_we    (load_wr),
    .ld_word  (load_word),
    .ld_data  (load_data),
    .host_we  (host_wr_ok),
    .host_addr(cfg_waddr),
    .host_data(cfg_wdata),
    .raddr    (cfg_raddr),
    .rdata    (cfg_rdata)
  );

  always_comb begin
    if (mode_q == MODE_PROG) begin
      {ee_cs, ee_sk, ee_di} = pin_sw_q;
    end else if (mode_q == MODE_AUTOLOAD) begin
      {ee_cs, ee_sk, ee_di} = {seq_cs, seq_sk, seq_di};
    end else begin
      {ee_cs, ee_sk, ee_di} = 3'b000;
    end
  end

  assign mirror    = ((mode_q == MODE_AUTOLOAD) || (mode_q == MODE_PROG)) ?
                     {ee_cs, ee_sk, ee_di, ee_do} : 4'h0;
  assign cmd_rdata = {mode_q, busy, 1'b0, mirror};
endmodule

// File: rtl/eel_chk.sv
module eel_chk #(
  parameter int DIV_W = 8,
  parameter int BA_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] sk_half,
  input logic [7:0]       cmd_rdata,
  input logic             busy,
  input logic             cfg_we,
  input logic [BA_W-1:0]  cfg_waddr,
  input logic [BA_W-1:0]  cfg_raddr,
  input logic [7:0]       cfg_rdata,
  input logic             ee_cs,
  input logic             ee_sk,
  input logic             ee_di,
  input logic             ee_do,
  input logic             seq_done,
  input logic             load_wr
);
  logic [1:0]  mode;
  logic        cs_q, armed_q;
  logic [15:0] gap_q;

  assign mode = cmd_rdata[7:6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else begin
      cs_q <= ee_cs;
      if (ee_cs)              gap_q <= '0;
      else if (gap_q != '1)   gap_q <= gap_q + 16'd1;
      if (!busy)              armed_q <= 1'b0;
      else if (cs_q && !ee_cs) armed_q <= 1'b1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) $rose(rst_n) |-> busy && mode == 2'b01); // R1
  AST_CS_ONLY_WHEN_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs && mode == 2'b01) |-> busy); // R2
  AST_MODE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (mode == 2'b00) && !busy); // R4
  AST_WORD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs && !cs_q && armed_q && mode == 2'b01) |-> gap_q >= {7'd0, sk_half, 1'b0}); // R5
  AST_SK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && mode == 2'b01) |-> ee_cs); // R6
  AST_PROTECTED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && mode != 2'b11 && !load_wr && cfg_raddr == cfg_waddr)
    |=> (cfg_raddr != $past(cfg_raddr)) || $stable(cfg_rdata)); // R7
  AST_PIN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 || mode == 2'b10) |-> cmd_rdata[3:0] == {ee_cs, ee_sk, ee_di, ee_do}); // R8
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |-> !ee_cs && !ee_sk && !ee_di && cmd_rdata[3:0] == 4'h0); // R9
endmodule

bind eeprom_cfg_loader eel_chk #(.DIV_W(DIV_W), .BA_W(BA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sk_half  (sk_half),
  .cmd_rdata(cmd_rdata),
  .busy     (busy),
  .cfg_we   (cfg_we),
  .cfg_waddr(cfg_waddr),
  .cfg_raddr(cfg_raddr),
  .cfg_rdata(cfg_rdata),
  .ee_cs    (ee_cs),
  .ee_sk    (ee_sk),
  .ee_di    (ee_di),
  .ee_do    (ee_do),
  .seq_done (seq_done),
  .load_wr  (load_wr)
);

// File: tb/eeprom_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module eeprom_cfg_loader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sk_half = 8'd2;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_wdata = 8'h00;
  logic [7:0] cmd_rdata;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_waddr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [5:0] cfg_raddr = '0;
  logic [7:0] cfg_rdata;
  logic       busy, ee_cs, ee_sk, ee_di, ee_do;
  logic       model_do = 1'b0, ovr_en = 1'b0, ovr_val = 1'b0;

  int checks = 0, errors = 0, cycles = 0;
  int seed = 1;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  assign ee_do = ovr_en ? ovr_val : model_do;

  eeprom_cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .sk_half(sk_half),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .busy(busy),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic logic [15:0] ee_word(input int a, input int s);
    return {8'hC0 ^ 8'(a), 8'(a * 5 + s * 17)};
  endfunction

  // Behavioural EEPROM: data changes on rising serial clock
  int       k = 0, n_cmds = 0, bad_prefix = 0;
  int       addr_log [64];
  logic [8:0] cmd_sr = '0;
  logic [5:0] rd_addr = '0;
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      k = 0;
      model_do <= 1'b0;
    end else begin
      k = k + 1;
      if (k <= 9) cmd_sr = {cmd_sr[7:0], ee_di};
      if (k == 9) begin
        if (cmd_sr[8:6] != 3'b110) bad_prefix = bad_prefix + 1;
        rd_addr = cmd_sr[5:0];
        addr_log[n_cmds % 64] = int'(cmd_sr[5:0]);
        n_cmds = n_cmds + 1;
        model_do <= 1'b0;
      end else if (k >= 10 && k <= 25) begin
        model_do <= ee_word(int'(rd_addr), seed)[25 - k];
      end
    end
  end

  // Pin timing monitor
  int hi_run = 0, last_hi = 0, low_run = 0, min_gap = 9999;
  logic cs_d = 1'b0, seen_word = 1'b0;
  always @(posedge clk) begin
    if (ee_sk) hi_run <= hi_run + 1;
    else begin
      if (hi_run != 0) last_hi <= hi_run;
      hi_run <= 0;
    end
    cs_d <= ee_cs;
    if (ee_cs) low_run <= 0; else low_run <= low_run + 1;
    if (!busy) seen_word <= 1'b0;
    else if (cs_d && !ee_cs) seen_word <= 1'b1;
    if (ee_cs && !cs_d && seen_word && busy && low_run < min_gap) min_gap <= low_run;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cmd_write(input logic [7:0] v);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic host_write(input logic [5:0] a, input logic [7:0] v);
    @(negedge clk); cfg_raddr = a; cfg_waddr = a; cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 60000) begin @(negedge clk); n++; end
    check(!busy, "R4 load did not finish", int'(busy), 0);
  endtask

  task automatic read_byte(input int a, output int v);
    @(negedge clk); cfg_raddr = 6'(a);
    @(negedge clk); v = int'(cfg_rdata);
  endtask

  localparam logic [5:0] CHK_ADDR [8] = '{6'd0, 6'd1, 6'd2, 6'd17, 6'd30, 6'd47, 6'd48, 6'd49};

  initial begin : watchdog
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int v, exp, base, mism;
    repeat (3) @(negedge clk);
    check(busy === 1'b1, "R1 busy during reset", int'(busy), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_rdata[7:6] == 2'b01 && busy, "R1 mode after reset", int'(cmd_rdata[7:5]), 3);
    cmd_write(8'hC0);  // ignored while busy
    check(cmd_rdata[7:6] == 2'b01, "R11 mode write during load", int'(cmd_rdata[7:6]), 1);
    wait_idle();
    @(negedge clk);
    check(cmd_rdata[7:6] == 2'b00, "R4 mode back to normal", int'(cmd_rdata[7:6]), 0);
    check(n_cmds == 25, "R2 word count", n_cmds, 25);
    mism = 0;
    for (int i = 0; i < 25; i++) if (addr_log[i] != i) mism++;
    check(mism == 0, "R2 address order", mism, 0);
    check(bad_prefix == 0, "R2 start/opcode bits", bad_prefix, 0);
    check(last_hi == 2, "R6 sk high time", last_hi, 2);
    check(min_gap >= 4, "R5 cs gap between words", min_gap, 4);

    for (int i = 0; i < 8; i++) begin
      read_byte(int'(CHK_ADDR[i]), v);
      exp = int'(ee_word(int'(CHK_ADDR[i]) / 2, seed) >> (8 * (int'(CHK_ADDR[i]) % 2))) & 8'hFF;
      check(v == exp, "R3 loaded byte", v, exp);
    end
    read_byte(50, v);
    check(v == 0, "R3 beyond loaded range", v, 0);

    read_byte(5, exp);
    host_write(6'd5, 8'h5A);
    @(negedge clk);
    check(int'(cfg_rdata) == exp, "R7 write in normal mode ignored", int'(cfg_rdata), exp);
    check(cmd_rdata[3:0] == 4'h0 && !ee_cs, "R9 idle pins in normal mode", int'(cmd_rdata[3:0]), 0);

    cmd_write(8'hC0);
    host_write(6'd5, 8'h5A);
    @(negedge clk);
    check(cfg_rdata == 8'h5A, "R7 write in config-write mode", int'(cfg_rdata), 'h5A);
    check(cmd_rdata[3:0] == 4'h0, "R9 mirror off in config-write mode", int'(cmd_rdata[3:0]), 0);

    cmd_write(8'b1000_1010);
    @(negedge clk);
    check({ee_cs, ee_sk, ee_di} == 3'b101, "R8 software pin drive", int'({ee_cs, ee_sk, ee_di}), 5);
    check(cmd_rdata[3:0] == 4'b1010, "R8 mirror with do low", int'(cmd_rdata[3:0]), 'hA);
    ovr_en = 1'b1; ovr_val = 1'b1;
    @(negedge clk);
    check(cmd_rdata[3:0] == 4'b1011, "R8 mirror with do high", int'(cmd_rdata[3:0]), 'hB);
    ovr_en = 1'b0;
    cmd_write(8'b1000_0100);
    check({ee_cs, ee_sk, ee_di} == 3'b010, "R8 sk driven by software", int'({ee_cs, ee_sk, ee_di}), 2);
    cmd_write(8'h00);

    seed = 2;
    sk_half = 8'd3;
    base = n_cmds;
    cmd_write(8'h40);
    check(busy && cmd_rdata[7:6] == 2'b01, "R10 software load start", int'(cmd_rdata[7:5]), 3);
    cmd_write(8'hC0);
    check(cmd_rdata[7:6] == 2'b01, "R11 mode write ignored while busy", int'(cmd_rdata[7:6]), 1);
    while (busy && !ee_cs) @(negedge clk);
    check(cmd_rdata[3] == ee_cs && cmd_rdata[0] == ee_do, "R8 mirror during load",
          int'(cmd_rdata[3:0]), int'({ee_cs, ee_sk, ee_di, ee_do}));
    wait_idle();
    check(n_cmds - base == 25, "R10 reload word count", n_cmds - base, 25);
    check(last_hi == 3, "R6 sk high time with divisor 6", last_hi, 3);
    read_byte(5, v);
    exp = int'(ee_word(2, 2) >> 8);
    check(v == exp, "R10 reload overwrites host byte", v, exp);
    read_byte(48, v);
    exp = int'(ee_word(24, 2)) & 8'hFF;
    check(v == exp, "R3 last word low byte after reload", v, exp);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule